// File: doc/BRIEF.md
# Data-Strobe Serial Link Receiver

This block turns a self-clocking data/strobe wire pair into a stream of received characters. One bit arrives whenever the exclusive OR of the two wires changes, and that bit is the value of the data wire. The bit stream is cut into characters of two sizes, chosen by a flag bit: a 10-bit data character or a 4-bit control character. Parity is checked on every character. Idle fill characters (an escape followed by a flow-control token) are discarded. Flow-control tokens are reported to the local transmitter. Data bytes and packet-end markers are stored in a receive FIFO.

Received entries leave the block on a valid/ready stream. `rx_valid` is high whenever the FIFO holds an entry, and `rx_data` shows the oldest one. An entry is removed only in a cycle where `rx_valid` and `rx_ready` are both high. While `rx_ready` is low, the entry and `rx_valid` stay as they are. No entry is ever lost, because the far end may only send as many normal characters as this block has promised room for.

The block keeps a count of outstanding credit: characters promised minus normal characters received. It raises `fct_req` when the FIFO can hold at least 8 more characters beyond that count. The transmitter answers each token it sends with a one-cycle `fct_sent`.

Top module: `dsr_top`

## Requirements
- R1: Every change of `ds_d` XOR `ds_s` delivers one bit, whose value is `ds_d` at that moment. The lines are taken as synchronous to `clk`, with at most one change per clock.
- R2: No character is decoded until the first idle fill has been seen. Before that point, bits produce no FIFO entry, no token pulse and no error.
- R3: A character is sent in this order: parity bit, flag bit, then payload with the least significant bit first. With flag 0, an 8-bit byte follows, and the byte is written to the FIFO as the 9-bit entry {0, byte}.
- R4: With flag 1, a 2-bit code follows, first bit as bit 0. The codes are 0 flow-control token, 1 end of packet, 2 error end of packet and 3 escape. End of packet is written as 0x100 and error end of packet as 0x101.
- R5: An escape followed by a flow-control token is idle fill and is dropped without effect. An escape followed by a data character is also dropped, with no entry and no error.
- R6: Each flow-control token that does not follow an escape gives a one-cycle pulse on `fct_rx`.
- R7: Parity is odd over the previous character's payload bits together with the current parity and flag bits. A mismatch sets the sticky `parity_err`, and from then on nothing is written to the FIFO until reset.
- R8: An escape followed by another control code (end of packet, error end of packet or escape) sets the sticky `escape_err`.
- R9: `fct_req` is high exactly when the free FIFO space is at least outstanding credit plus 8, and outstanding credit is at most 48. When `fct_sent` is high in a cycle where `fct_req` is high, 8 is added to the credit. When `fct_req` is low, `fct_sent` has no effect.
- R10: Outstanding credit never exceeds 56. When a token grant and a normal character fall in the same cycle, the credit changes by +7.
- R11: A normal character (data, end of packet, error end of packet) that arrives when outstanding credit is zero sets the sticky `credit_err` and is not stored.
- R12: The FIFO side follows valid/ready. Entries come out in arrival order. While `rx_ready` is low, `rx_valid` and `rx_data` hold steady, and the FIFO is never written when full.
- R13: After reset, `rx_valid` is low, all three error flags are clear, credit is zero and `fct_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ds_d | input | 1 | Data wire |
| ds_s | input | 1 | Strobe wire |
| rx_valid | output | 1 | FIFO holds an entry |
| rx_ready | input | 1 | Consumer accepts the entry |
| rx_data | output | 9 | Oldest entry: {marker, byte} |
| fct_rx | output | 1 | One-cycle pulse per received flow-control token |
| fct_req | output | 1 | Request to send a flow-control token |
| fct_sent | input | 1 | Transmitter sent one token (adds 8 credit) |
| parity_err | output | 1 | Sticky parity error |
| escape_err | output | 1 | Sticky escape sequence error |
| credit_err | output | 1 | Sticky credit overrun |

## Verification
The interaction that matters is a token grant on `fct_sent` landing in the same clock as the credit decrement for an arriving character. If either update is lost, the credit count drifts. The bench brings credit to 48, sends a data character, and raises `fct_sent` in the cycle the character is counted. It then sends characters one at a time and expects `fct_req` to stay low after six and rise after the seventh, which only happens if the net change was +7. FIFO writes and reads also fall together while the consumer stays ready, and the scoreboard judges that by arrival order.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    CC_FCT  = 2'd0,
    CC_EOP  = 2'd1,
    CC_EEOP = 2'd2,
    CC_ESC  = 2'd3
  } ctrl_code_e;

  localparam int CHUNK    = 8;   // characters of credit per token
  localparam int DATA_LEN = 10;  // parity + flag + 8 payload bits
  localparam int CTRL_LEN = 4;   // parity + flag + 2 payload bits
  localparam logic [8:0] MARK_EOP  = 9'h100;
  localparam logic [8:0] MARK_EEOP = 9'h101;
endpackage

// File: rtl/dsr_bitrec.sv
module dsr_bitrec (
  input  logic clk,
  input  logic rst_n,
  input  logic line_d,
  input  logic line_s,
  output logic bit_vld,
  output logic bit_val
);
  logic x_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q     <= 1'b0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      x_q     <= line_d ^ line_s;
      bit_vld <= (line_d ^ line_s) != x_q;
      bit_val <= line_d;
    end
  end
endmodule

// File: rtl/dsr_chardec.sv
module dsr_chardec
  import dsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_val,
  output logic       ev_wr,
  output logic [8:0] ev_data,
  output logic       ev_fct,
  output logic       par_err,
  output logic       esc_err
);
  localparam logic [6:0] NULL_PAT = 7'b1110100;

  logic       aligned, par_q, flag_q, px, esc_pend, last;
  logic [5:0] hunt;
  logic [3:0] cnt, idx;
  logic [7:0] pay, pay_n;
  ctrl_code_e code;

  assign idx  = cnt - 4'd2;
  assign last = flag_q ? (cnt == 4'(CTRL_LEN - 1)) : (cnt == 4'(DATA_LEN - 1));
  assign code = ctrl_code_e'(pay_n[1:0]);

  always_comb begin
    pay_n = pay;
    pay_n[idx[2:0]] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned  <= 1'b0;
      hunt     <= '0;
      cnt      <= '0;
      par_q    <= 1'b0;
      flag_q   <= 1'b0;
      px       <= 1'b0;
      esc_pend <= 1'b0;
      pay      <= '0;
      ev_wr    <= 1'b0;
      ev_data  <= '0;
      ev_fct   <= 1'b0;
      par_err  <= 1'b0;
      esc_err  <= 1'b0;
    end else begin
      ev_wr  <= 1'b0;
      ev_fct <= 1'b0;
      if (bit_vld && !par_err) begin
        if (!aligned) begin
          hunt <= {hunt[4:0], bit_val};
          if ({hunt, bit_val} == NULL_PAT) begin
            aligned  <= 1'b1;
            cnt      <= '0;
            px       <= 1'b0;
            esc_pend <= 1'b0;
          end
        end else if (cnt == 4'd0) begin
          par_q <= bit_val;
          cnt   <= 4'd1;
        end else if (cnt == 4'd1) begin
          if ((px ^ par_q ^ bit_val) == 1'b0) par_err <= 1'b1;
          flag_q <= bit_val;
          cnt    <= 4'd2;
        end else begin
          pay <= pay_n;
          cnt <= last ? 4'd0 : cnt + 4'd1;
          if (last) begin
            if (flag_q) begin
              px <= ^pay_n[1:0];
              if (esc_pend) begin
                esc_pend <= 1'b0;
                if (code != CC_FCT) esc_err <= 1'b1;
              end else begin
                case (code)
                  CC_FCT:  ev_fct <= 1'b1;
                  CC_EOP:  begin ev_wr <= 1'b1; ev_data <= MARK_EOP;  end
                  CC_EEOP: begin ev_wr <= 1'b1; ev_data <= MARK_EEOP; end
                  default: esc_pend <= 1'b1;
                endcase
              end
            end else begin
              px <= ^pay_n;
              if (esc_pend) begin
                esc_pend <= 1'b0;
              end else begin
                ev_wr   <= 1'b1;
                ev_data <= {1'b0, pay_n};
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsr_fifo.sv
module dsr_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   free,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [FW-1:0] count;
  logic          do_wr, do_rd;

  assign rd_valid = count != '0;
  assign full     = count == FW'(DEPTH);
  assign free     = FW'(DEPTH) - count;
  assign rd_data  = mem[rptr];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + AW'(1);
      if (do_rd) rptr <= rptr + AW'(1);
      count <= count + (do_wr ? FW'(1) : '0) - (do_rd ? FW'(1) : '0);
    end
  end
endmodule

// File: rtl/dsr_credit.sv
module dsr_credit
  import dsr_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CREDIT_MAX = 56
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                nchar,
  input  logic                                grant,
  input  logic [$clog2(DEPTH+1)-1:0]          free,
  output logic                                fct_req,
  output logic                                accept,
  output logic                                crd_err,
  output logic [$clog2(CREDIT_MAX+1)-1:0]     credit_q
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(CREDIT_MAX + 1);
  localparam int SW = ((FW > CW) ? FW : CW) + 1;

  logic [SW-1:0] need;
  logic          take;

  assign need    = SW'(credit_q) + SW'(CHUNK);
  assign fct_req = (SW'(free) >= need) && (credit_q <= CW'(CREDIT_MAX - CHUNK));
  assign take    = grant && fct_req;
  assign accept  = nchar && (credit_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= '0;
      crd_err  <= 1'b0;
    end else begin
      credit_q <= credit_q + (take ? CW'(CHUNK) : '0) - (accept ? CW'(1) : '0);
      if (nchar && credit_q == '0) crd_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dsr_top.sv
module dsr_top #(
  parameter int FIFO_DEPTH = 64,
  parameter int CREDIT_MAX = 56
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ds_d,
  input  logic       ds_s,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [8:0] rx_data,
  output logic       fct_rx,
  output logic       fct_req,
  input  logic       fct_sent,
  output logic       parity_err,
  output logic       escape_err,
  output logic       credit_err
);
  localparam int FW = $clog2(FIFO_DEPTH + 1);
  localparam int CW = $clog2(CREDIT_MAX + 1);

  logic          bit_vld, bit_val, ev_wr, fifo_wr, fifo_full;
  logic [8:0]    ev_data;
  logic [FW-1:0] fifo_free;
  logic [CW-1:0] credit_q;

  dsr_bitrec u_bitrec (
    .clk(clk), .rst_n(rst_n), .line_d(ds_d), .line_s(ds_s),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  dsr_chardec u_dec (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .ev_wr(ev_wr), .ev_data(ev_data), .ev_fct(fct_rx),
    .par_err(parity_err), .esc_err(escape_err)
  );

  dsr_credit #(.DEPTH(FIFO_DEPTH), .CREDIT_MAX(CREDIT_MAX)) u_credit (
    .clk(clk), .rst_n(rst_n), .nchar(ev_wr), .grant(fct_sent),
    .free(fifo_free), .fct_req(fct_req), .accept(fifo_wr),
    .crd_err(credit_err), .credit_q(credit_q)
  );

  dsr_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(ev_data),
    .rd_valid(rx_valid), .rd_ready(rx_ready), .rd_data(rx_data),
    .free(fifo_free), .full(fifo_full)
  );
endmodule

// File: rtl/dsr_chk.sv
module dsr_chk #(
  parameter int CREDIT_MAX = 56
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rx_valid,
  input logic                            rx_ready,
  input logic [8:0]                      rx_data,
  input logic                            fct_rx,
  input logic                            fct_req,
  input logic                            fct_sent,
  input logic                            parity_err,
  input logic [$clog2(CREDIT_MAX+1)-1:0] credit,
  input logic                            fifo_wr,
  input logic                            fifo_full
);
  localparam int CW = $clog2(CREDIT_MAX + 1);

  // R10
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CW'(CREDIT_MAX));

  // R10
  grant_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fct_sent && fct_req) |=>
      (credit == $past(credit) + CW'(8)) || (credit == $past(credit) + CW'(7)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);

  // R7
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> parity_err);

  // R7
  par_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> !fifo_wr);

  // R6
  fct_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fct_rx |=> !fct_rx);
endmodule

bind dsr_top dsr_chk #(.CREDIT_MAX(CREDIT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .fct_rx(fct_rx), .fct_req(fct_req), .fct_sent(fct_sent),
  .parity_err(parity_err), .credit(credit_q), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full)
);

// File: tb/dsr_top_tb.sv
module dsr_top_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ds_d = 1'b0, ds_s = 1'b0, rx_ready = 1'b0, fct_sent = 1'b0;
  logic rx_valid, fct_rx, fct_req, parity_err, escape_err, credit_err;
  logic [8:0] rx_data;

  int checks = 0, failures = 0;
  int pushed = 0, popped = 0, fct_cnt = 0, mcred = 0;
  logic px = 1'b0;
  logic [8:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  dsr_top u_dut (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fct_rx(fct_rx), .fct_req(fct_req), .fct_sent(fct_sent),
    .parity_err(parity_err), .escape_err(escape_err), .credit_err(credit_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: sample away from the edges
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected entry", int'(rx_data), 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R3/R4/R12 entry", int'(rx_data), int'(e));
      end
      popped++;
    end
    if (rst_n && fct_rx) fct_cnt++;
  end

  function automatic bit exp_req();
    int free;
    free = DEPTH - (pushed - popped);
    return (free - mcred >= 8) && (mcred <= 48);
  endfunction

  task automatic send_bit(input logic b);
    logic x;
    x = ~(ds_d ^ ds_s);
    ds_s = x ^ b;
    ds_d = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(input logic flag, input logic [7:0] pay, input bit badpar);
    int n;
    logic p, pp;
    n = flag ? 2 : 8;
    p = 1'b1 ^ px ^ flag ^ logic'(badpar);
    send_bit(p);
    send_bit(flag);
    pp = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_bit(pay[i]);
      pp = pp ^ pay[i];
    end
    px = pp;
  endtask

  task automatic send_data(input logic [7:0] b, input bit expect_store);
    send_char(1'b0, b, 0);
    if (expect_store) begin
      exp_q.push_back({1'b0, b});
      pushed++;
      mcred--;
    end
  endtask

  task automatic send_ctrl(input logic [1:0] code);
    send_char(1'b1, {6'd0, code}, 0);
  endtask

  task automatic send_null();
    send_ctrl(2'd3);
    send_ctrl(2'd0);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ds_d = 1'b0; ds_s = 1'b0; fct_sent = 1'b0; rx_ready = 1'b0;
    px = 1'b0; mcred = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    pushed = 0; popped = 0; fct_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic grant();
    bit e;
    e = exp_req();
    chk(fct_req == e, "R9 request before grant", int'(fct_req), int'(e));
    fct_sent = 1'b1;
    @(negedge clk);
    fct_sent = 1'b0;
    if (e) mcred += 8;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    do_reset();
    chk(rx_valid == 0, "R13 rx_valid", int'(rx_valid), 0);
    chk({parity_err, escape_err, credit_err} == 3'b000, "R13 flags",
        int'({parity_err, escape_err, credit_err}), 0);
    chk(fct_req == 1, "R13 fct_req", int'(fct_req), 1);

    // R9: seven grants reach 56, the eighth is ignored
    for (int i = 0; i < 8; i++) grant();
    chk(mcred == 56, "R10 model credit", mcred, 56);

    // R2: stray bits before alignment are ignored; R1 bit recovery
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_null();
    send_data(8'hA5, 1);
    send_ctrl(2'd1); exp_q.push_back(9'h100); pushed++; mcred--;   // R4 end of packet
    send_ctrl(2'd0);                                               // R6 token
    send_null();                                                   // R5 dropped
    send_data(8'h3C, 1);
    send_ctrl(2'd2); exp_q.push_back(9'h101); pushed++; mcred--;   // R4 error end
    send_ctrl(2'd3); send_data(8'h77, 0);                          // R5 escape+data dropped
    send_data(8'h11, 1);
    settle();
    chk(rx_valid == 1 && rx_data == 9'h0A5, "R12 held head", int'(rx_data), 9'h0A5);
    repeat (5) @(negedge clk);
    chk(rx_data == 9'h0A5, "R12 stable while not ready", int'(rx_data), 9'h0A5);
    chk(fct_req == exp_req(), "R9 request with full-ish credit", int'(fct_req), int'(exp_req()));
    rx_ready = 1'b1;
    settle();
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    chk(fct_cnt == 1, "R6 token pulses", fct_cnt, 1);
    chk(escape_err == 0, "R5 no escape error", int'(escape_err), 0);

    // R10: bring credit to 48, then a grant collides with a counted character
    while (mcred > 48) send_data(8'h20, 1);
    settle();
    chk(fct_req == 1, "R9 request at 48", int'(fct_req), 1);
    send_data(8'h5A, 1);
    fct_sent = 1'b1;                 // same cycle as the credit decrement
    @(negedge clk);
    fct_sent = 1'b0;
    mcred += 8;
    for (int i = 0; i < 6; i++) send_data(8'(i), 1);
    settle();
    chk(fct_req == 0, "R10 credit 49 after collision", int'(fct_req), 0);
    send_data(8'hEE, 1);
    settle();
    chk(fct_req == 1, "R10 credit 48 after collision", int'(fct_req), 1);
    chk(credit_err == 0, "R11 no credit error", int'(credit_err), 0);

    // R8 escape then end of packet
    send_ctrl(2'd3); send_ctrl(2'd1);
    settle();
    chk(escape_err == 1, "R8 escape error", int'(escape_err), 1);
    chk(exp_q.size() == 0, "R8 nothing stored", exp_q.size(), 0);

    // R11 character without credit
    do_reset();
    rx_ready = 1'b1;
    send_null();
    send_data(8'h42, 0);
    settle();
    chk(credit_err == 1, "R11 credit error", int'(credit_err), 1);
    chk(rx_valid == 0, "R11 not stored", int'(rx_valid), 0);

    // R2 data before alignment, then R7 parity error
    do_reset();
    rx_ready = 1'b1;
    grant();
    send_data(8'hFF, 0);
    settle();
    chk(rx_valid == 0 && credit_err == 0, "R2 pre-alignment ignored",
        int'({rx_valid, credit_err}), 0);
    send_null();
    send_char(1'b0, 8'h99, 1);
    settle();
    chk(parity_err == 1, "R7 parity error", int'(parity_err), 1);
    send_data(8'h12, 0);
    settle();
    chk(rx_valid == 0, "R7 writes stopped", int'(rx_valid), 0);
    chk(exp_q.size() == 0, "R7 queue empty", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule